// File: doc/BRIEF.md
# Packed Lane Multiplier

This block multiplies two 128-bit operand vectors lane by lane, treating them either as sixteen 8-bit lanes or as eight 16-bit lanes. A mode input chooses the result shape: keep the lower or upper half of every lane product, widen the products of only the even-numbered or only the odd-numbered lanes to double width, or sum the signed products of neighbouring lanes into double-width lanes.

It sits in a vector execution pipeline as a fixed-latency unit. An operation is accepted on every cycle in which `in_valid` is high. The result appears two clock cycles later with `out_valid` high. The unit has no stall and no back-pressure. Lane 0 always occupies the least significant bits of both operands and of the result.

Top module: `simd_mul_unit`

## Requirements
- R1: `out_valid` equals the `in_valid` value from two rising edges earlier, and it is 0 while `rst_n` is low and for the first two edges after release.
- R2: Mode 0 (low half) with 16-bit lanes: result lane i is bits [15:0] of `a` lane i times `b` lane i. The result is the same whatever the value of `is_signed`.
- R3: Mode 1 (high half) with 16-bit lanes: result lane i is bits [31:16] of the product. The operands are two's complement when `is_signed` is 1 and unsigned when it is 0.
- R4: Mode 2 (even widening): result lane j, of double width, is the full product of operand lanes 2j. With 8-bit lanes this gives eight 16-bit results, and with 16-bit lanes it gives four 32-bit results. `is_signed` selects the signedness of both operands.
- R5: Mode 3 (odd widening): the same as R4, but using operand lanes 2j+1.
- R6: Mode 4 (pair sum) with 16-bit lanes: result lane j (32 bits) is the signed product of lanes 2j plus the signed product of lanes 2j+1, modulo 2^32. When all four inputs are -32768, the result is 0x80000000.
- R7: With `elem8`=1, modes 0 and 1 keep bits [7:0] or bits [15:8] of each 8-bit lane product. Mode 1 honours `is_signed`.
- R8: Mode 4 with `elem8`=1 sums the signed byte products of neighbouring lanes into 16-bit lanes modulo 2^16. Mode 4 always treats the operands as signed, whatever `is_signed` says, so four inputs of -128 give 0x8000.
- R9: Lane k of a vector is bits [W*k+W-1 : W*k], where W is the lane width. Lane 0 sits in the least significant bits.
- R10: Mode codes 5, 6 and 7 produce an all-zero result, and valid still travels with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| mode | input | 3 | Result shape: 0 low, 1 high, 2 even, 3 odd, 4 pair sum |
| elem8 | input | 1 | 1 = 8-bit lanes, 0 = 16-bit lanes |
| is_signed | input | 1 | 1 = two's complement operands (ignored in mode 4) |
| a | input | 128 | First operand vector |
| b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result present on out_data |
| out_data | output | 128 | Result vector |

## Verification
Directed vectors come first.
- The all-minimum pair-sum case, in both lane widths, separates a correct wrap from a saturating one. The 8-bit case, run with `is_signed` low, also shows that the signedness input is forced in pair mode.
- All-ones operands in high mode separate the signed result (0x0000) from the unsigned result (0xFFFE).
- A vector with a distinct value in every lane exposes any lane reversal or any mix-up between even and odd lanes.

After that, several thousand random operations cover all eight mode codes, both lane widths, both signedness settings and random gaps in `in_valid`. The gaps show that valid keeps its two-cycle spacing when traffic is bursty.

// File: rtl/simd_mul_pkg.sv
// Shared definitions for the packed lane multiplier.
// Assumes: mode codes above MUL_PAIR are reserved and produce zero.
package simd_mul_pkg;
    typedef enum logic [2:0] {
        MUL_LO   = 3'd0,
        MUL_HI   = 3'd1,
        MUL_EVEN = 3'd2,
        MUL_ODD  = 3'd3,
        MUL_PAIR = 3'd4
    } mul_mode_e;
endpackage

// File: rtl/simd_lane_mul.sv
// One lane multiplier of parameterised width.
// Each operand is extended by one bit: a copy of its sign bit when sgn is high,
// and zero otherwise. The two are then multiplied as signed numbers, so one
// multiplier serves both signedness variants.
// Assumes: only the low 2*W bits of the product are of interest.
module simd_lane_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           sgn,
    output logic [2*W-1:0] prod
);
    logic signed [W:0]     ext_a;
    logic signed [W:0]     ext_b;
    logic signed [2*W+1:0] full;

    // Extend both operands and form the product.
    always_comb begin
        ext_a = {sgn & op_a[W-1], op_a};
        ext_b = {sgn & op_b[W-1], op_b};
        full  = ext_a * ext_b;
        prod  = full[2*W-1:0];
    end
endmodule

// File: rtl/simd_mul_array.sv
// Stage 1: two banks of lane multipliers, one of 8-bit lanes and one of
// 16-bit lanes, with their products and controls registered.
// Assumes: VEC_W is a multiple of 64. Pair mode forces signed operands.
module simd_mul_array
    import simd_mul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            mode,
    input  logic                  elem8,
    input  logic                  is_signed,
    input  logic [VEC_W-1:0]      a,
    input  logic [VEC_W-1:0]      b,
    output logic                  s1_valid,
    output logic [2:0]            s1_mode,
    output logic                  s1_elem8,
    output logic [2*VEC_W-1:0]    s1_bprod,
    output logic [2*VEC_W-1:0]    s1_hprod
);
    localparam int NB = VEC_W / 8;
    localparam int NH = VEC_W / 16;

    logic               sgn_eff;
    logic [2*VEC_W-1:0] bprod;
    logic [2*VEC_W-1:0] hprod;

    // Pair-sum mode always multiplies as signed.
    always_comb sgn_eff = is_signed | (mode == MUL_PAIR);

    genvar gk;
    generate
        for (gk = 0; gk < NB; gk++) begin : g_byte
            simd_lane_mul #(.W(8)) u_bmul (
                .op_a (a[8*gk +: 8]),
                .op_b (b[8*gk +: 8]),
                .sgn  (sgn_eff),
                .prod (bprod[16*gk +: 16])
            );
        end
        for (gk = 0; gk < NH; gk++) begin : g_half
            simd_lane_mul #(.W(16)) u_hmul (
                .op_a (a[16*gk +: 16]),
                .op_b (b[16*gk +: 16]),
                .sgn  (sgn_eff),
                .prod (hprod[32*gk +: 32])
            );
        end
    endgenerate

    // Valid flag for stage 1, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Capture products and controls only when an operation is accepted.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_mode  <= mode;
            s1_elem8 <= elem8;
            s1_bprod <= bprod;
            s1_hprod <= hprod;
        end
    end

    AST_S1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);                                  // R1
    AST_S1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_valid);                                // R1
endmodule

// File: rtl/simd_mul_format.sv
// Stage 2: selects and combines the registered products into the result
// shape given by the mode, then registers the result.
// Assumes: the product buses hold the full 2W-bit product of every lane.
module simd_mul_format
    import simd_mul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s1_valid,
    input  logic [2:0]            s1_mode,
    input  logic                  s1_elem8,
    input  logic [2*VEC_W-1:0]    s1_bprod,
    input  logic [2*VEC_W-1:0]    s1_hprod,
    output logic                  out_valid,
    output logic [VEC_W-1:0]      out_data
);
    localparam int NB = VEC_W / 8;
    localparam int NH = VEC_W / 16;
    localparam int NW = VEC_W / 32;

    logic [VEC_W-1:0] res;

    // Build the result vector for the current mode and lane width.
    always_comb begin
        res = '0;
        case (s1_mode)
            MUL_LO: begin
                if (s1_elem8)
                    for (int k = 0; k < NB; k++) res[8*k +: 8] = s1_bprod[16*k +: 8];
                else
                    for (int i = 0; i < NH; i++) res[16*i +: 16] = s1_hprod[32*i +: 16];
            end
            MUL_HI: begin
                if (s1_elem8)
                    for (int k = 0; k < NB; k++) res[8*k +: 8] = s1_bprod[16*k+8 +: 8];
                else
                    for (int i = 0; i < NH; i++) res[16*i +: 16] = s1_hprod[32*i+16 +: 16];
            end
            MUL_EVEN, MUL_ODD: begin
                if (s1_elem8)
                    for (int j = 0; j < NH; j++)
                        res[16*j +: 16] = s1_bprod[16*(2*j + int'(s1_mode == MUL_ODD)) +: 16];
                else
                    for (int j = 0; j < NW; j++)
                        res[32*j +: 32] = s1_hprod[32*(2*j + int'(s1_mode == MUL_ODD)) +: 32];
            end
            MUL_PAIR: begin
                if (s1_elem8)
                    for (int j = 0; j < NH; j++)
                        res[16*j +: 16] = s1_bprod[32*j +: 16] + s1_bprod[32*j+16 +: 16];
                else
                    for (int j = 0; j < NW; j++)
                        res[32*j +: 32] = s1_hprod[64*j +: 32] + s1_hprod[64*j+32 +: 32];
            end
            default: res = '0;
        endcase
    end

    // Output valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    // Register the result when stage 1 holds an operation.
    always_ff @(posedge clk) begin
        if (s1_valid) out_data <= res;
    end

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);                                 // R1
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);                               // R1
endmodule

// File: rtl/simd_mul_unit.sv
// Packed lane multiplier top level.
// The unit has two register stages: the products, then the formatted result.
// Valid travels beside the data, and there is no stall.
// Assumes: VEC_W is a multiple of 64. Inputs are ignored when in_valid is low.
module simd_mul_unit
    import simd_mul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       mode,
    input  logic             elem8,
    input  logic             is_signed,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    localparam int NW = VEC_W / 32;

    logic               s1_valid;
    logic [2:0]         s1_mode;
    logic               s1_elem8;
    logic [2*VEC_W-1:0] s1_bprod;
    logic [2*VEC_W-1:0] s1_hprod;

    simd_mul_array #(.VEC_W(VEC_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .elem8     (elem8),
        .is_signed (is_signed),
        .a         (a),
        .b         (b),
        .s1_valid  (s1_valid),
        .s1_mode   (s1_mode),
        .s1_elem8  (s1_elem8),
        .s1_bprod  (s1_bprod),
        .s1_hprod  (s1_hprod)
    );

    simd_mul_format #(.VEC_W(VEC_W)) u_format (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_mode   (s1_mode),
        .s1_elem8  (s1_elem8),
        .s1_bprod  (s1_bprod),
        .s1_hprod  (s1_hprod),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_PAIR_MIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MUL_PAIR && !elem8 && a == {(VEC_W/16){16'h8000}}
         && b == {(VEC_W/16){16'h8000}}) |=> ##1 (out_data == {NW{32'h8000_0000}})); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode > MUL_PAIR) |=> ##1 (out_valid && out_data == '0)); // R10
    AST_HI_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MUL_HI && a == '0) |=> ##1 (out_data == '0)); // R3
endmodule

// File: tb/tb_simd_mul_unit.sv
`timescale 1ns/1ps
module tb_simd_mul_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         elem8 = 1'b0;
    logic         is_signed = 1'b0;
    logic [127:0] a = '0;
    logic [127:0] b = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    bit           qv[$];
    logic [127:0] qd[$];
    string        qt[$];

    always #4 clk = ~clk;

    simd_mul_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .elem8(elem8), .is_signed(is_signed), .a(a), .b(b),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Requirement tag covered by a mode / lane-width combination.
    function automatic string tag_of(logic [2:0] m, bit e8);
        if (m > 3'd4) return "R10";
        if (m == 3'd0) return e8 ? "R7" : "R2";
        if (m == 3'd1) return e8 ? "R7" : "R3";
        if (m == 3'd2) return "R4";
        if (m == 3'd3) return "R5";
        return e8 ? "R8" : "R6";
    endfunction

    // Behavioural reference result, computed on integers.
    function automatic logic [127:0] model(logic [2:0] m, bit e8, bit sg,
                                           logic [127:0] x, logic [127:0] y);
        logic [127:0] r = '0;
        logic [63:0]  p[16];
        bit s = sg || (m == 3'd4);
        int n = e8 ? 16 : 8;
        int w = e8 ? 8 : 16;
        for (int k = 0; k < n; k++) begin
            longint xi, yi;
            if (e8) begin
                xi = s ? longint'($signed(x[8*k +: 8]))  : longint'(x[8*k +: 8]);
                yi = s ? longint'($signed(y[8*k +: 8]))  : longint'(y[8*k +: 8]);
            end else begin
                xi = s ? longint'($signed(x[16*k +: 16])) : longint'(x[16*k +: 16]);
                yi = s ? longint'($signed(y[16*k +: 16])) : longint'(y[16*k +: 16]);
            end
            p[k] = 64'(xi * yi);
        end
        for (int k = n; k < 16; k++) p[k] = '0;
        for (int k = 0; k < n; k++) begin
            if (m == 3'd0) begin
                if (e8) r[8*k +: 8] = p[k][7:0]; else r[16*k +: 16] = p[k][15:0];
            end else if (m == 3'd1) begin
                if (e8) r[8*k +: 8] = p[k][15:8]; else r[16*k +: 16] = p[k][31:16];
            end
        end
        for (int j = 0; j < n / 2; j++) begin
            logic [63:0] sum = p[2*j] + p[2*j+1];
            if (m == 3'd2) begin
                if (e8) r[16*j +: 16] = p[2*j][15:0]; else r[32*j +: 32] = p[2*j][31:0];
            end else if (m == 3'd3) begin
                if (e8) r[16*j +: 16] = p[2*j+1][15:0]; else r[32*j +: 32] = p[2*j+1][31:0];
            end else if (m == 3'd4) begin
                if (e8) r[16*j +: 16] = sum[15:0]; else r[32*j +: 32] = sum[31:0];
            end
        end
        if (w == 0) r = '0;
        return r;
    endfunction

    // One cycle: compare the result due now, then drive the next operation.
    task automatic step(bit v, logic [2:0] m, bit e8, bit sg,
                        logic [127:0] x, logic [127:0] y, string t);
        @(negedge clk);
        if (qv.size() == 2) begin
            bit           ev = qv.pop_front();
            logic [127:0] ed = qd.pop_front();
            string        et = qt.pop_front();
            nvec++;
            if (out_valid !== ev) begin
                nfail++;
                $display("FAIL R1: out_valid=%0b expected %0b", out_valid, ev);
            end else if (ev && out_data !== ed) begin
                nfail++;
                $display("FAIL %s: out_data=%h expected %h", et, out_data, ed);
            end
        end
        in_valid  = v;
        mode      = m;
        elem8     = e8;
        is_signed = sg;
        a         = x;
        b         = y;
        qv.push_back(v);
        qd.push_back(model(m, e8, sg, x, y));
        qt.push_back(t == "" ? tag_of(m, e8) : t);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL R1: watchdog expired, actual hang expected completion");
        report();
    end

    initial begin
        logic [127:0] seq;
        repeat (5) @(negedge clk);
        // R1: reset state.
        nvec++;
        if (out_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R1: out_valid in reset=%0b expected 0", out_valid);
        end
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) seq[16*i +: 16] = 16'(i + 1) | (16'(i + 9) << 8);

        // R6: all-minimum wraps to 0x80000000.
        step(1, 3'd4, 0, 1, {8{16'h8000}}, {8{16'h8000}}, "R6");
        // R8: byte pair sum, signedness input ignored.
        step(1, 3'd4, 1, 0, {16{8'h80}}, {16{8'h80}}, "R8");
        // R3: all-ones, unsigned then signed high half.
        step(1, 3'd1, 0, 0, {8{16'hFFFF}}, {8{16'hFFFF}}, "R3");
        step(1, 3'd1, 0, 1, {8{16'hFFFF}}, {8{16'hFFFF}}, "R3");
        // R2: low half independent of signedness.
        step(1, 3'd0, 0, 1, {8{16'hFFFF}}, {8{16'h1234}}, "R2");
        // R9: distinct lanes, low half, multiplier one.
        step(1, 3'd0, 0, 0, seq, {8{16'h0001}}, "R9");
        step(1, 3'd0, 1, 0, seq, {16{8'h01}}, "R9");
        // R4 / R5: even and odd widening over distinct lanes.
        step(1, 3'd2, 0, 1, seq, {8{16'hFFFF}}, "R4");
        step(1, 3'd3, 0, 1, seq, {8{16'hFFFF}}, "R5");
        step(1, 3'd2, 1, 0, seq, {16{8'hFF}}, "R4");
        step(1, 3'd3, 1, 0, seq, {16{8'hFF}}, "R5");
        // R7: byte high half, signed.
        step(1, 3'd1, 1, 1, {16{8'h80}}, {16{8'h7F}}, "R7");
        // R10: reserved code.
        step(1, 3'd7, 0, 1, seq, seq, "R10");
        // R1: a bubble.
        step(0, 3'd0, 0, 0, '0, '0, "R1");

        for (int n = 0; n < 4000; n++) begin
            logic [127:0] x = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] y = {$urandom, $urandom, $urandom, $urandom};
            step(($urandom % 4) != 0, 3'($urandom % 8), 1'($urandom % 2),
                 1'($urandom % 2), x, y, "");
        end
        step(0, 3'd0, 0, 0, '0, '0, "R1");
        step(0, 3'd0, 0, 0, '0, '0, "R1");
        step(0, 3'd0, 0, 0, '0, '0, "R1");
        report();
    end
endmodule